// File: doc/BRIEF.md
# Command ring packet parser

This block walks a circular ring of 32-bit command words in memory, starting at its own read pointer and stopping at a write pointer that software advances. It fetches one word at a time through a simple request/response read port. It reads the type field of each packet header and then handles the packet in one of four ways:

- A register-write packet becomes a series of register write transactions.
- A one-word no-op is stepped over.
- A command packet is handed downstream as a header beat (opcode, predicate flag, length) followed by its payload words.
- A reserved type is flagged as an error and skipped.

The block counts the packets it completes and pulses a done signal when it catches up with software. Both pointers count words and never wrap. A pointer is reduced modulo the ring size only when a memory address is built from it. The ring size is programmed as log2 of its size in bytes. The parser never starts a packet whose words have not all been published by the write pointer.

Top module: `cmd_ring_walker`

## Requirements
- R1: After reset, rd_ptr is 0, pkt_count is 0, err is 0, no output strobe or memory request is active, and idle is 1 while wr_ptr is 0.
- R2: Every fetch uses mem_addr = cfg_base + 4 * (rd_ptr mod W), where W = 2^(cfg_size_log2 - 2) words, so the ring wraps from its last word back to its first.
- R3: With cfg_size_log2 below 2 the ring has zero size: no memory request is made and rd_ptr holds. Fetching resumes once a valid size is restored.
- R4: A header with bits 31:30 = 0 is a register-write packet. Bits 29:16 give the payload count minus one, and bits 14:0 give the first register index. Each payload word appears once on reg_wr_data with reg_wr_en. The index increases by 1 per word and wraps within 15 bits.
- R5: In a register-write packet with header bit 15 set, every payload word is written to the same starting index.
- R6: A header with bits 31:30 = 3 is a command packet. It raises cmd_hdr_valid for one cycle with cmd_opcode = bits 14:8, cmd_pred = bit 0, and cmd_len = bits 29:16. It then presents each payload word once on cmd_word with cmd_word_valid, and cmd_word_last is set only on the final word.
- R7: A header with bits 31:30 = 2 is consumed as a single word. It produces no register write and no command output.
- R8: A header with bits 31:30 = 1 sets err, which stays set until reset. The word is skipped and is not counted as a packet.
- R9: If fewer than count + 2 words lie between rd_ptr and wr_ptr when a header is examined, the parser produces no output and keeps rd_ptr unchanged until wr_ptr covers the whole packet.
- R10: pkt_count increases by exactly 1 for each completed register-write, no-op or command packet.
- R11: done pulses for one cycle when the parser is idle with rd_ptr equal to wr_ptr, provided at least one packet has completed since the previous pulse. If wr_ptr advances before that point is reached, no pulse is given until the new work drains.
- R12: rd_ptr increases by exactly 1 for each word consumed and is never reduced modulo the ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Byte address of ring word 0 |
| cfg_size_log2 | input | 5 | log2 of ring size in bytes |
| wr_ptr | input | 32 | Unwrapped word pointer written by software |
| rd_ptr | output | 32 | Unwrapped word pointer of the next word to consume |
| mem_req | output | 1 | Read request for mem_addr |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid for the outstanding request |
| mem_rdata | input | 32 | Read data |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_idx | output | 15 | Register index of the write |
| reg_wr_data | output | 32 | Register write data |
| cmd_hdr_valid | output | 1 | Command packet header beat |
| cmd_opcode | output | 7 | Command opcode |
| cmd_pred | output | 1 | Command predicate flag |
| cmd_len | output | 14 | Command payload count minus one |
| cmd_word_valid | output | 1 | Command payload word strobe |
| cmd_word | output | 32 | Command payload word |
| cmd_word_last | output | 1 | Marks the final payload word |
| pkt_count | output | 32 | Completed packet count |
| err | output | 1 | Sticky reserved-type error |
| idle | output | 1 | Parser idle with nothing to fetch |
| done | output | 1 | One-cycle drained pulse |

## Verification
The parser can catch up with the write pointer in the same cycle that software publishes more words. This is the point where a done pulse and a new header fetch compete. The bench provokes it by watching rd_ptr at the falling edge and raising wr_ptr on the very half-cycle where rd_ptr first equals the old target. It then requires exactly one done pulse across both batches and the completion of both packets. It also lets the ring wrap inside a register burst and inside a command payload, so that address reduction and payload sequencing are exercised together.

// File: rtl/cmd_ring_walker.sv
`timescale 1ns/1ps
module cmd_ring_walker #(
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 32,
  parameter int LOG2_W = 5,
  parameter int CNT_OUT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic [LOG2_W-1:0]    cfg_size_log2,
  input  logic [PTR_W-1:0]     wr_ptr,
  output logic [PTR_W-1:0]     rd_ptr,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rvalid,
  input  logic [31:0]          mem_rdata,
  output logic                 reg_wr_en,
  output logic [14:0]          reg_wr_idx,
  output logic [31:0]          reg_wr_data,
  output logic                 cmd_hdr_valid,
  output logic [6:0]           cmd_opcode,
  output logic                 cmd_pred,
  output logic [13:0]          cmd_len,
  output logic                 cmd_word_valid,
  output logic [31:0]          cmd_word,
  output logic                 cmd_word_last,
  output logic [CNT_OUT_W-1:0] pkt_count,
  output logic                 err,
  output logic                 idle,
  output logic                 done
);
  localparam int CNT_W = 14;
  localparam int IDX_W = 15;

  typedef enum logic [2:0] {S_IDLE, S_HWAIT, S_CHECK, S_PREQ, S_PWAIT} st_t;
  st_t st;

  logic [1:0]       h_type;
  logic [CNT_W-1:0] h_cnt;
  logic             h_wone;
  logic [IDX_W-1:0] h_idx;
  logic [CNT_W-1:0] left;
  logic [IDX_W-1:0] ridx;
  logic             since;

  logic [PTR_W-1:0] size_words, ring_mask, avail, need;
  logic             ring_on, go, fits;

  assign size_words = (cfg_size_log2 >= LOG2_W'(2)) ?
                      (PTR_W'(1) << (cfg_size_log2 - LOG2_W'(2))) : '0;
  assign ring_on    = size_words != '0;
  assign ring_mask  = size_words - PTR_W'(1);
  assign avail      = wr_ptr - rd_ptr;
  assign need       = PTR_W'(h_cnt) + PTR_W'(2);
  assign fits       = avail >= need;
  assign go         = ring_on && (rd_ptr != wr_ptr);

  assign mem_req  = ((st == S_IDLE) && go) || (st == S_PREQ);
  assign mem_addr = cfg_base + ADDR_W'({rd_ptr & ring_mask, 2'b00});
  assign idle     = (st == S_IDLE) && ((rd_ptr == wr_ptr) || !ring_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rd_ptr <= '0;
      h_type <= '0;
      h_cnt <= '0;
      h_wone <= 1'b0;
      h_idx <= '0;
      left <= '0;
      ridx <= '0;
      since <= 1'b0;
      pkt_count <= '0;
      err <= 1'b0;
      done <= 1'b0;
      reg_wr_en <= 1'b0;
      reg_wr_idx <= '0;
      reg_wr_data <= '0;
      cmd_hdr_valid <= 1'b0;
      cmd_opcode <= '0;
      cmd_pred <= 1'b0;
      cmd_len <= '0;
      cmd_word_valid <= 1'b0;
      cmd_word <= '0;
      cmd_word_last <= 1'b0;
    end else begin
      done <= 1'b0;
      reg_wr_en <= 1'b0;
      cmd_hdr_valid <= 1'b0;
      cmd_word_valid <= 1'b0;
      cmd_word_last <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) st <= S_HWAIT;
          else if (since && rd_ptr == wr_ptr) begin
            done <= 1'b1;
            since <= 1'b0;
          end
        end
        S_HWAIT: begin
          if (mem_rvalid) begin
            h_type <= mem_rdata[31:30];
            h_cnt  <= mem_rdata[29:16];
            h_wone <= mem_rdata[15];
            h_idx  <= mem_rdata[14:0];
            st <= S_CHECK;
          end
        end
        S_CHECK: begin
          case (h_type)
            2'd2: begin
              rd_ptr <= rd_ptr + PTR_W'(1);
              pkt_count <= pkt_count + CNT_OUT_W'(1);
              since <= 1'b1;
              st <= S_IDLE;
            end
            2'd1: begin
              rd_ptr <= rd_ptr + PTR_W'(1);
              err <= 1'b1;
              st <= S_IDLE;
            end
            default: begin
              if (fits) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
                left <= h_cnt;
                ridx <= h_idx;
                if (h_type == 2'd3) begin
                  cmd_hdr_valid <= 1'b1;
                  cmd_opcode <= h_idx[14:8];
                  cmd_pred <= h_idx[0];
                  cmd_len <= h_cnt;
                end
                st <= S_PREQ;
              end
            end
          endcase
        end
        S_PREQ: st <= S_PWAIT;
        S_PWAIT: begin
          if (mem_rvalid) begin
            rd_ptr <= rd_ptr + PTR_W'(1);
            if (h_type == 2'd0) begin
              reg_wr_en <= 1'b1;
              reg_wr_idx <= ridx;
              reg_wr_data <= mem_rdata;
              if (!h_wone) ridx <= ridx + IDX_W'(1);
            end else begin
              cmd_word_valid <= 1'b1;
              cmd_word <= mem_rdata;
              cmd_word_last <= (left == '0);
            end
            if (left == '0) begin
              pkt_count <= pkt_count + CNT_OUT_W'(1);
              since <= 1'b1;
              st <= S_IDLE;
            end else begin
              left <= left - CNT_W'(1);
              st <= S_PREQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_ring_walker_chk.sv
`timescale 1ns/1ps
module cmd_ring_walker_chk #(
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 32,
  parameter int LOG2_W = 5,
  parameter int CNT_OUT_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    cfg_base,
  input logic [LOG2_W-1:0]    cfg_size_log2,
  input logic [PTR_W-1:0]     rd_ptr,
  input logic                 mem_req,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic                 reg_wr_en,
  input logic                 cmd_word_valid,
  input logic [CNT_OUT_W-1:0] pkt_count,
  input logic                 err,
  input logic                 done
);
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] off;
  assign span = (ADDR_W+1)'(1) << cfg_size_log2;
  assign off  = mem_addr - cfg_base;

  // R3
  ring_off_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cfg_size_log2 >= LOG2_W'(2)));
  // R2
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (({1'b0, off} < span) && (off[1:0] == 2'b00)));
  // R12
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr == $past(rd_ptr)) || (rd_ptr == $past(rd_ptr) + PTR_W'(1)));
  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count == $past(pkt_count)) || (pkt_count == $past(pkt_count) + CNT_OUT_W'(1)));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  one_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && cmd_word_valid));
endmodule

bind cmd_ring_walker cmd_ring_walker_chk #(
  .PTR_W(PTR_W), .ADDR_W(ADDR_W), .LOG2_W(LOG2_W), .CNT_OUT_W(CNT_OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
  .rd_ptr(rd_ptr), .mem_req(mem_req), .mem_addr(mem_addr),
  .reg_wr_en(reg_wr_en), .cmd_word_valid(cmd_word_valid),
  .pkt_count(pkt_count), .err(err), .done(done)
);

// File: tb/cmd_ring_walker_test.sv
`timescale 1ns/1ps
module cmd_ring_walker_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [31:0] cfg_base, wr_ptr, rd_ptr, mem_addr, mem_rdata, reg_wr_data, cmd_word, pkt_count;
  logic [4:0]  cfg_size_log2;
  logic mem_req, mem_rvalid, reg_wr_en, cmd_hdr_valid, cmd_pred, cmd_word_valid, cmd_word_last;
  logic err, idle, done;
  logic [14:0] reg_wr_idx;
  logic [6:0]  cmd_opcode;
  logic [13:0] cmd_len;

  cmd_ring_walker uut (.*);

  logic [31:0] mem [64];
  int checks = 0, errors = 0, cyc = 0;
  int rw_n = 0, cw_n = 0, ch_n = 0, done_n = 0, req_n = 0, bad_addr = 0;
  logic [14:0] rw_idx [256];
  logic [31:0] rw_dat [256];
  logic [31:0] cw_dat [256];
  logic        cw_last [256];
  logic [6:0]  ch_opc;
  logic        ch_pred;
  logic [13:0] ch_len;
  logic [31:0] wp_soft = 0;

  // Ring: base 0x80, 64 bytes = 16 words -> mem[32..47]
  always @(posedge clk) begin
    mem_rvalid <= mem_req && rst_n;
    mem_rdata  <= mem[mem_addr[7:2]];
  end

  always @(negedge clk) if (rst_n) begin
    if (reg_wr_en) begin rw_idx[rw_n] = reg_wr_idx; rw_dat[rw_n] = reg_wr_data; rw_n++; end
    if (cmd_hdr_valid) begin ch_opc = cmd_opcode; ch_pred = cmd_pred; ch_len = cmd_len; ch_n++; end
    if (cmd_word_valid) begin cw_dat[cw_n] = cmd_word; cw_last[cw_n] = cmd_word_last; cw_n++; end
    if (done) done_n++;
    if (mem_req) begin
      req_n++;
      if (mem_addr < 32'h80 || mem_addr >= 32'hC0 || mem_addr[1:0] != 0) bad_addr++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    mem[32 + (wp_soft % 16)] = w;
    wp_soft++;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    while (!idle) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R12 watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] VEC [6] = '{
    32'h0002_0010,  // reg burst idx 0x10, 3 words
    32'h0001_8020,  // write-one idx 0x20, 2 words
    32'hC003_2A00,  // command op 0x2A, 4 words
    32'hC000_7F01,  // command op 0x7F, predicated, 1 word
    32'h8000_0000,  // no-op
    32'h0003_7FFE   // reg burst idx 0x7FFE, 4 words, index wraps
  };

  initial begin
    int rw0, cw0, ch0, d0, rq0;
    logic [31:0] pc0, rd0, target;
    for (int i = 0; i < 64; i++) mem[i] = 32'h8000_0000;
    rst_n = 1'b0; cfg_base = 32'h80; cfg_size_log2 = 5'd6; wr_ptr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_ptr", rd_ptr, 0);
    chk("R1 pkt_count", pkt_count, 0);
    chk("R1 err", {31'b0, err}, 0);
    chk("R1 idle", {31'b0, idle}, 1);
    chk("R1 strobes", {28'b0, mem_req, reg_wr_en, cmd_word_valid, done}, 0);

    for (int e = 0; e < 6; e++) begin
      logic [31:0] h;
      int n;
      h = VEC[e];
      n = (h[31:30] == 2) ? 0 : int'(h[29:16]) + 1;
      rw0 = rw_n; cw0 = cw_n; ch0 = ch_n; pc0 = pkt_count;
      put(h);
      for (int k = 0; k < n; k++) put(32'hA000_0000 + e * 256 + k);
      wr_ptr = wp_soft;
      drain();
      chk("R10 count", pkt_count, pc0 + 1);
      chk("R12 rd_ptr", rd_ptr, wp_soft);
      if (h[31:30] == 0) begin
        chk("R4 writes", rw_n - rw0, n);
        for (int k = 0; k < n; k++) begin
          logic [14:0] ei;
          ei = h[15] ? h[14:0] : 15'(h[14:0] + k);
          chk(h[15] ? "R5 idx" : "R4 idx", {17'b0, rw_idx[rw0 + k]}, {17'b0, ei});
          chk("R4 data", rw_dat[rw0 + k], 32'hA000_0000 + e * 256 + k);
        end
      end else if (h[31:30] == 3) begin
        chk("R6 hdr beats", ch_n - ch0, 1);
        chk("R6 opcode", {25'b0, ch_opc}, {25'b0, h[14:8]});
        chk("R6 pred", {31'b0, ch_pred}, {31'b0, h[0]});
        chk("R6 len", {18'b0, ch_len}, {18'b0, h[29:16]});
        chk("R6 words", cw_n - cw0, n);
        for (int k = 0; k < n; k++) begin
          chk("R6 data", cw_dat[cw0 + k], 32'hA000_0000 + e * 256 + k);
          chk("R6 last", {31'b0, cw_last[cw0 + k]}, (k == n - 1) ? 1 : 0);
        end
      end else begin
        chk("R7 silent", rw_n - rw0 + cw_n - cw0 + ch_n - ch0, 0);
      end
    end
    chk("R11 done per drain", done_n, 6);
    chk("R2 address window", bad_addr, 0);

    // R8 reserved type
    pc0 = pkt_count; d0 = done_n; rw0 = rw_n;
    put(32'h4000_0000); wr_ptr = wp_soft; drain();
    chk("R8 err", {31'b0, err}, 1);
    chk("R8 skip", rd_ptr, wp_soft);
    chk("R8 not counted", pkt_count, pc0);
    chk("R8 no done", done_n, d0);

    // R9 stall until payload published
    pc0 = pkt_count; rw0 = rw_n;
    put(32'h0002_0040); put(32'h11); put(32'h22); put(32'h33);
    wr_ptr = wp_soft - 1;
    rd0 = rd_ptr;
    repeat (30) @(negedge clk);
    chk("R9 rd held", rd_ptr, rd0);
    chk("R9 no writes", rw_n - rw0, 0);
    wr_ptr = wp_soft; drain();
    chk("R9 writes after release", rw_n - rw0, 3);
    chk("R9 last data", rw_dat[rw0 + 2], 32'h33);
    chk("R9 count", pkt_count, pc0 + 1);
    chk("R8 err still set", {31'b0, err}, 1);

    // R11 catch-up meets new write pointer in the same cycle
    pc0 = pkt_count; d0 = done_n;
    put(32'h8000_0000); put(32'h8000_0000);
    target = wp_soft - 1; wr_ptr = target;
    while (rd_ptr != target) @(negedge clk);
    wr_ptr = wp_soft;
    drain();
    chk("R11 single done", done_n, d0 + 1);
    chk("R11 both packets", pkt_count, pc0 + 2);

    // R3 zero-size ring
    cfg_size_log2 = 5'd1;
    put(32'h8000_0000); wr_ptr = wp_soft;
    rq0 = req_n; rd0 = rd_ptr;
    repeat (20) @(negedge clk);
    chk("R3 no request", req_n, rq0);
    chk("R3 rd held", rd_ptr, rd0);
    cfg_size_log2 = 5'd6;
    drain();
    chk("R3 resumes", rd_ptr, wp_soft);
    chk("R2 address window final", bad_addr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule